// File: doc/BRIEF.md
# DC-Balanced Pixel Word Framer

This block turns a parallel pixel interface into a serial bit stream. The interface carries 18 video bits, 9 control bits and a data-enable flag. One pixel slot lasts twenty strobes of the bit enable `bit_en`. On the first strobe of each slot the block samples the interface, reports the sample on `pix_take`, and loads the next 20-bit word into its output shifter. Each later strobe moves the word one place toward `ser_out`, lowest bit first. Words follow each other with no gap.

While data-enable is high, a slot carries a video word. While it is low, a slot carries a control word, in which five of the control bits are sent three times each so that a receiver can vote. Around every edge of data-enable the block sends a fixed transition word in place of control data. Two such slots come before video starts and two come after it ends. To see an edge before it reaches the output, the block holds samples in a short look-ahead window, so a word leaves three slots after its sample was taken. A running disparity count decides whether each payload is sent as is or inverted. The overhead bits record that choice, which keeps the line DC balanced.

A phase machine names the kind of each outgoing word. Its states are CTRL (control word), LEAD (transition word before video), VIDEO (video word) and TRAIL (transition word after video). After reset the machine is in CTRL. It moves CTRL to LEAD when a high data-enable sits within the look-ahead, and LEAD to VIDEO when that sample reaches the centre of the window. It moves VIDEO to TRAIL when the centre sample is low, and TRAIL to CTRL when no high sample lies on either side. It moves TRAIL to LEAD when the next video lies ahead and the last one is more than two slots behind. It moves TRAIL to VIDEO when the blanking gap was only one or two slots long.

Top module: `pixel_word_framer`

## Requirements
- R1: Each word is shifted out lowest bit first, one bit per `bit_en` strobe, 20 bits per word, with no gap between words. `word_start` is high exactly while bit 0 of a word is on `ser_out`.
- R2: `pix_take` is high on the first `bit_en` strobe after reset and on every 20th strobe after that. The inputs are sampled in that cycle, and each sampling strobe also loads a new word.
- R3: A video word has bit 0 = inv, bit 1 = not inv, and bits 2..19 = video bits 0..17, each XOR inv.
- R4: A control word has bit 0 = inv. Bits 3j+1..3j+3 hold control bit j for j = 0..4, and bits 16..19 hold control bits 5..8. Every payload bit is XOR inv.
- R5: inv is 1 exactly when the running disparity and the payload disparity (number of ones times 2, minus the payload width) are both nonzero and have the same sign. After each word the running disparity adds (number of ones in the word times 2) minus 20. Its magnitude never exceeds 20.
- R6: The two slots before a rising data-enable carry the transition word 20'h380FB, which leaves the running disparity unchanged.
- R7: The two slots after a falling data-enable carry the transition word. A blanking gap of one to four slots is made up of transition words only.
- R8: Control inputs are ignored in transition and video slots, and video inputs are ignored while data-enable is low.
- R9: The word loaded at sampling strobe n is built from the sample taken at strobe n-3. Data-enable from strobes n-5..n-1 decides its kind.
- R10: After reset, `ser_out`, `word_start` and the disparity are 0. All samples in the window read as control words of zeros.
- R11: With `bit_en` low, `ser_out` and the word position stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit strobe; advances the serial output by one bit |
| de_in | input | 1 | Data-enable: high selects video, low selects control |
| video_in | input | 18 | Video pixel bits |
| ctrl_in | input | 9 | Control bits |
| pix_take | output | 1 | High in the cycle the inputs are sampled |
| word_start | output | 1 | High while bit 0 of a word is on the output |
| ser_out | output | 1 | Serial data, lowest bit first |

## Verification
A wrong phase state would show as a wrong kind of word three slots after the data-enable edge that caused it. For example, a control word could replace a transition word, or video could start with no lead-in. That error is visible within the 20 bits of that slot. A disparity counter that goes wrong flips the choice of inversion. That flips both overhead bits and the whole payload of the first word whose sign decision changes, and it usually shows within one or two slots. A bit counter that slips moves `pix_take` and `word_start` away from 20-strobe boundaries and breaks every later word comparison at once.

// File: rtl/frm_pkg.sv
package frm_pkg;
    localparam int VID_W    = 18;
    localparam int CTL_W    = 9;
    localparam int TRIP_N   = 5;
    localparam int SINGLE_N = CTL_W - TRIP_N;
    localparam int CPAY_W   = 3 * TRIP_N + SINGLE_N;
    localparam int WORD_W   = VID_W + 2;
    localparam int CNT_W    = $clog2(WORD_W);

    // Balanced marker: bits[1:0]=11 (no video word has equal overhead bits),
    // bits[3:1]=101 (no control word has a broken first triple).
    localparam logic [WORD_W-1:0] TRANS_WORD = 20'h380FB;

    typedef enum logic [1:0] {
        PH_CTRL  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_VIDEO = 2'd2,
        PH_TRAIL = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        WK_CTRL  = 2'd0,
        WK_VIDEO = 2'd1,
        WK_TRANS = 2'd2
    } kind_t;
endpackage

// File: rtl/frm_bit_timer.sv
module frm_bit_timer
    import frm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    output logic take,
    output logic first
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt_q;

    assign take  = bit_en && (cnt_q == LAST);
    assign first = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= LAST;
        end else if (bit_en) begin
            cnt_q <= take ? '0 : cnt_q + 1'b1;
        end
    end

    AST_TAKE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take); // R2

    AST_FIRST_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> first); // R1
endmodule

// File: rtl/frm_capture_window.sv
module frm_capture_window
    import frm_pkg::*;
#(
    parameter int LOOK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              de_in,
    input  logic [VID_W-1:0]  video_in,
    input  logic [CTL_W-1:0]  ctrl_in,
    output logic [2*LOOK:0]   de_win,
    output logic [VID_W-1:0]  vid_c,
    output logic [CTL_W-1:0]  ctl_c
);
    localparam int HIST_N = 2 * LOOK + 1;
    localparam int DATA_N = LOOK + 1;

    logic [HIST_N-1:0] hist_q;
    logic [VID_W-1:0]  vpipe [DATA_N];
    logic [CTL_W-1:0]  cpipe [DATA_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (take) begin
            hist_q <= {hist_q[HIST_N-2:0], de_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DATA_N; i++) begin
                vpipe[i] <= '0;
                cpipe[i] <= '0;
            end
        end else if (take) begin
            if (de_in) begin
                vpipe[0] <= video_in;
            end else begin
                cpipe[0] <= ctrl_in;
            end
            for (int i = 1; i < DATA_N; i++) begin
                vpipe[i] <= vpipe[i-1];
                cpipe[i] <= cpipe[i-1];
            end
        end
    end

    assign de_win = hist_q;
    assign vid_c  = vpipe[LOOK];
    assign ctl_c  = cpipe[LOOK];

    AST_VIDEO_HELD_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !de_in) |=> $stable(vpipe[0])); // R8

    AST_CTRL_HELD_IN_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
        (take && de_in) |=> $stable(cpipe[0])); // R8
endmodule

// File: rtl/frm_phase_fsm.sv
module frm_phase_fsm
    import frm_pkg::*;
#(
    parameter int LOOK = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [2*LOOK:0] de_win,
    output kind_t           kind
);
    phase_t state_q;
    phase_t state_nxt;
    logic   cen;
    logic   ahead;
    logic   behind;

    assign cen    = de_win[LOOK];
    assign ahead  = |de_win[LOOK-1:0];
    assign behind = |de_win[2*LOOK:LOOK+1];

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            PH_CTRL:  state_nxt = ahead ? PH_LEAD : PH_CTRL;
            PH_LEAD:  state_nxt = cen ? PH_VIDEO : PH_LEAD;
            PH_VIDEO: state_nxt = cen ? PH_VIDEO : PH_TRAIL;
            PH_TRAIL: begin
                if (cen)         state_nxt = PH_VIDEO;
                else if (behind) state_nxt = PH_TRAIL;
                else if (ahead)  state_nxt = PH_LEAD;
                else             state_nxt = PH_CTRL;
            end
            default:  state_nxt = PH_CTRL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_CTRL;
        end else if (take) begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        kind = WK_CTRL;
        unique case (state_nxt)
            PH_CTRL:  kind = WK_CTRL;
            PH_VIDEO: kind = WK_VIDEO;
            PH_LEAD:  kind = WK_TRANS;
            PH_TRAIL: kind = WK_TRANS;
            default:  kind = WK_CTRL;
        endcase
    end

    AST_NO_DIRECT_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
        (take && state_q == PH_CTRL) |-> (state_nxt != PH_VIDEO)); // R6

    AST_CTRL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (take && state_nxt == PH_CTRL) |-> (state_q == PH_CTRL || state_q == PH_TRAIL)); // R7

    AST_TRAIL_AFTER_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
        (take && state_q == PH_VIDEO && state_nxt != PH_VIDEO) |=> (state_q == PH_TRAIL)); // R7
endmodule

// File: rtl/frm_encoder_shift.sv
module frm_encoder_shift
    import frm_pkg::*;
#(
    parameter int RD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             take,
    input  kind_t            kind,
    input  logic [VID_W-1:0] vid,
    input  logic [CTL_W-1:0] ctl,
    output logic             ser_out
);
    logic [CPAY_W-1:0]      cpay;
    logic [WORD_W-1:0]      word;
    logic [WORD_W-1:0]      sreg_q;
    logic signed [RD_W-1:0] rd_q;
    logic                   inv;
    int                     rd_i;
    int                     pay_disp;
    int                     word_disp;
    int                     rd_sum;

    for (genvar j = 0; j < TRIP_N; j++) begin : g_triple
        assign cpay[3*j +: 3] = {3{ctl[j]}};
    end
    for (genvar k = 0; k < SINGLE_N; k++) begin : g_single
        assign cpay[3*TRIP_N + k] = ctl[TRIP_N + k];
    end

    always_comb begin
        rd_i     = int'(rd_q);
        pay_disp = (kind == WK_VIDEO) ? (2 * $countones(vid) - VID_W)
                                      : (2 * $countones(cpay) - CPAY_W);
        inv      = ((rd_i > 0) && (pay_disp > 0)) || ((rd_i < 0) && (pay_disp < 0));
        word     = TRANS_WORD;
        unique case (kind)
            WK_VIDEO: word = {vid ^ {VID_W{inv}}, ~inv, inv};
            WK_CTRL:  word = {cpay ^ {CPAY_W{inv}}, inv};
            WK_TRANS: word = TRANS_WORD;
            default:  word = TRANS_WORD;
        endcase
        word_disp = 2 * $countones(word) - WORD_W;
        rd_sum    = rd_i + word_disp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            rd_q   <= '0;
        end else if (take) begin
            sreg_q <= word;
            rd_q   <= rd_sum[RD_W-1:0];
        end else if (bit_en) begin
            sreg_q <= {1'b0, sreg_q[WORD_W-1:1]};
        end
    end

    assign ser_out = sreg_q[0];

    AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_q) <= WORD_W) && (int'(rd_q) >= -WORD_W)); // R5

    AST_RD_PULLS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind != WK_TRANS && rd_q > 0) |=> (rd_q <= $past(rd_q))); // R5

    AST_TRANS_KEEPS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == WK_TRANS) |=> (rd_q == $past(rd_q))); // R6

    AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !take) |=> (ser_out == $past(sreg_q[1]))); // R1

    AST_VIDEO_EN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == WK_VIDEO) |=> (sreg_q[0] != sreg_q[1])); // R3

    AST_CTRL_TRIPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == WK_CTRL) |=> (sreg_q[3:1] == 3'b000 || sreg_q[3:1] == 3'b111)); // R4
endmodule

// File: rtl/pixel_word_framer.sv
module pixel_word_framer
    import frm_pkg::*;
#(
    parameter int LOOK = 2,
    parameter int RD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             de_in,
    input  logic [VID_W-1:0] video_in,
    input  logic [CTL_W-1:0] ctrl_in,
    output logic             pix_take,
    output logic             word_start,
    output logic             ser_out
);
    logic             take;
    logic             first;
    logic [2*LOOK:0]  de_win;
    logic [VID_W-1:0] vid_c;
    logic [CTL_W-1:0] ctl_c;
    kind_t            kind;

    frm_bit_timer u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .take   (take),
        .first  (first)
    );

    frm_capture_window #(.LOOK(LOOK)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .de_in    (de_in),
        .video_in (video_in),
        .ctrl_in  (ctrl_in),
        .de_win   (de_win),
        .vid_c    (vid_c),
        .ctl_c    (ctl_c)
    );

    frm_phase_fsm #(.LOOK(LOOK)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .de_win (de_win),
        .kind   (kind)
    );

    frm_encoder_shift #(.RD_W(RD_W)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .take    (take),
        .kind    (kind),
        .vid     (vid_c),
        .ctl     (ctl_c),
        .ser_out (ser_out)
    );

    assign pix_take   = take;
    assign word_start = first;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(ser_out) && $stable(word_start))); // R11
endmodule

// File: tb/pixel_word_framer_test.sv
module pixel_word_framer_test;
    localparam int NS = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        de_in = 1'b0;
    logic [17:0] video_in = '0;
    logic [8:0]  ctrl_in = '0;
    logic        pix_take;
    logic        word_start;
    logic        ser_out;

    always #5 clk = ~clk;

    pixel_word_framer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .de_in      (de_in),
        .video_in   (video_in),
        .ctrl_in    (ctrl_in),
        .pix_take   (pix_take),
        .word_start (word_start),
        .ser_out    (ser_out)
    );

    int errs = 0;
    int checks = 0;

    logic        de_s [NS];
    logic [17:0] v_s  [NS];
    logic [8:0]  c_s  [NS];

    logic [19:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic dv(input int i);
        if (i < 0 || i >= NS) return 1'b0;
        return de_s[i];
    endfunction

    // kind: 0 control, 1 video, 2 transition
    function automatic logic [19:0] model_word(input int kind, input logic [17:0] v,
                                               input logic [8:0] c, inout int rd);
        logic [18:0] p;
        logic [19:0] w;
        int dp;
        logic inv;
        for (int j = 0; j < 5; j++) begin
            for (int k = 0; k < 3; k++) p[3*j+k] = c[j];
        end
        for (int i = 0; i < 4; i++) p[15+i] = c[5+i];
        if (kind == 1) dp = 2 * $countones(v) - 18;
        else           dp = 2 * $countones(p) - 19;
        inv = ((rd > 0) && (dp > 0)) || ((rd < 0) && (dp < 0));
        if (kind == 2)      w = 20'h380FB;
        else if (kind == 1) w = {v ^ {18{inv}}, ~inv, inv};
        else                w = {p ^ {19{inv}}, inv};
        rd = rd + 2 * $countones(w) - 20;
        return w;
    endfunction

    task automatic build_stimulus();
        int runs [11] = '{5, 6, 1, 3, 2, 1, 3, 5, 4, 4, 8};
        int idx = 0;
        logic lvl = 1'b0;
        int unsigned x = 32'h1234_5678;
        for (int r = 0; r < 11; r++) begin
            for (int q = 0; q < runs[r]; q++) begin
                de_s[idx] = lvl;
                idx++;
            end
            lvl = ~lvl;
        end
        while (idx < NS) begin
            de_s[idx] = 1'b0;
            idx++;
        end
        for (int i = 0; i < NS; i++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            v_s[i] = x[17:0];
            c_s[i] = x[30:22];
        end
        v_s[5] = '1;
        v_s[6] = '0;
        v_s[7] = 18'h3FFFE;
        c_s[2] = 9'h1FF;
        c_s[3] = 9'h01F;
    endtask

    task automatic build_expected();
        int rd = 0;
        for (int n = 0; n < NS; n++) begin
            int m = n - 3;
            int kind;
            string tag;
            logic [17:0] v = (m >= 0) ? v_s[m] : '0;
            logic [8:0]  c = (m >= 0) ? c_s[m] : '0;
            if (dv(m)) begin
                kind = 1; tag = "R3 R5 R9 video word";
            end else if (dv(m - 1) || dv(m - 2)) begin
                kind = 2; tag = "R7 R8 trailing transition";
            end else if (dv(m + 1) || dv(m + 2)) begin
                kind = 2; tag = "R6 R8 leading transition";
            end else begin
                kind = 0;
                tag = (m < 0) ? "R10 R4 reset window word" : "R4 R5 R8 control word";
            end
            exp_q.push_back(model_word(kind, v, c, rd));
            tag_q.push_back(tag);
        end
    endtask

    // Scoreboard monitor
    logic        adv_q = 1'b0;
    int          bit_idx = 0;
    int          word_no = 0;
    logic [19:0] cur = '0;
    logic        last_bit = 1'b0;
    bit          seen = 0;

    always @(posedge clk) adv_q <= bit_en && rst_n;

    always @(negedge clk) begin
        if (rst_n && adv_q) begin
            chk(word_start == (bit_idx == 0), "R1 word_start marker", 32'(word_start), 32'(bit_idx == 0));
            cur[bit_idx] = ser_out;
            last_bit = ser_out;
            seen = 1;
            if (bit_idx == 19) begin
                logic [19:0] e;
                string t;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected extra word", 32'(cur), 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if (cur !== e) begin
                        errs++;
                        $display("FAIL %s: word %0d actual %05h expected %05h", t, word_no, cur, e);
                    end
                end
                word_no++;
                bit_idx = 0;
            end else begin
                bit_idx++;
            end
        end else if (rst_n && seen) begin
            chk(ser_out == last_bit, "R11 idle hold", 32'(ser_out), 32'(last_bit));
        end
    end

    // Driver
    bit done = 0;
    initial begin
        build_stimulus();
        build_expected();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ser_out == 1'b0, "R10 reset ser_out", 32'(ser_out), 32'h0);
        chk(word_start == 1'b0, "R10 reset word_start", 32'(word_start), 32'h0);
        chk(pix_take == 1'b0, "R10 reset pix_take", 32'(pix_take), 32'h0);
        repeat (2) @(negedge clk);
        chk(ser_out == 1'b0, "R11 R10 idle after reset", 32'(ser_out), 32'h0);
        for (int n = 0; n < NS; n++) begin
            de_in    = de_s[n];
            video_in = v_s[n];
            ctrl_in  = c_s[n];
            for (int p = 0; p < 20; p++) begin
                bit_en = 1'b1;
                #1;
                chk(pix_take == (p == 0), "R2 sampling strobe", 32'(pix_take), 32'(p == 0));
                @(negedge clk);
                if (((n * 7 + p) % 6) == 5) begin
                    bit_en = 1'b0;
                    repeat ((n % 3) + 1) @(negedge clk);
                end
            end
        end
        bit_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 R1 all words delivered", 32'(exp_q.size()), 32'h0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule